// File: doc/BRIEF.md
# 8-bit Timer/Counter with One Output Compare Channel

This block is an 8-bit counter that advances on a selectable count enable and drives one waveform pin from a single compare channel. The enable can be stopped, every clock, one of two prescaled rates, or an already synchronized external tick. The counter runs in one of four modes: free-running, cleared on compare, fast single-slope PWM and phase-correct dual-slope PWM.

Software reaches the block through a small register port. A write takes effect on the clock edge at which `wr_en` is high. Reads are combinational from `addr`. There is no streaming data path, so every pin is a plain control or status signal.

Register map (`addr`):
- 0 is control: `[2:0]` clock source, `[4:3]` counting mode, `[6:5]` output action, `[7]` force strobe (write only, reads 0).
- 1 is the counter.
- 2 is the compare value. A read returns the last written value.
- 3 holds the flags: `[0]` overflow, `[1]` compare.
- 4 holds the interrupt enables, with the same bit positions as the flags.

Top module: `tmr_oc`

## Requirements
- R1: With clock source 0 the counter holds its value. Ticks on `ext_tick` are ignored. Register 1 still reads back and accepts writes.
- R2: A write to register 1 loads the counter even when a count or a clear falls on the same edge.
- R3: The clock source field selects the count enable:
  - 1 gives one tick per clock.
  - 2 gives one tick every 8 clocks.
  - 3 gives one tick every 64 clocks.
  - 4 gives one tick per clock in which `ext_tick` is high.
  - 0, 5, 6 and 7 stop the counter.
- R4: The compare flag (register 3 bit 1) is set by the tick taken while the counter equals the active compare value. It is not set while the match is only present.
- R5: The flags clear in two ways: by writing 1 to their bit in register 3, or by pulsing `ack_ovf` or `ack_cmp`. A set on the same edge wins over a clear. `irq_ovf` and `irq_cmp` are each flag ANDed with its enable in register 4.
- R6: Mode 1 (clear on compare) loads 0 into the counter on the tick taken at a match. In the non-PWM modes 0 and 1, that tick applies the output action: 1 toggles, 2 clears, 3 sets.
- R7: In modes 0 to 2 the counter wraps from 0xFF to 0x00, and the wrapping tick sets the overflow flag. In mode 3 the overflow flag is set by the tick taken at 0x00.
- R8: In modes 0 and 1 a compare write takes effect at once. In modes 2 and 3 it goes to a buffer, which is copied to the active compare value on the tick taken at 0xFF.
- R9: Mode 2 (fast PWM) behaves as follows:
  - With action 2, the tick at 0xFF sets the pin and the tick at a match clears it. The set wins if both fall on the same tick.
  - Over one 256-tick period the pin is high for compare+1 ticks.
  - Action 3 gives the complement.
- R10: Mode 3 (phase-correct PWM) counts 0 up to 0xFF and back down to 0, a period of 510 ticks.
  - With action 2, a match while counting up clears the pin and a match while counting down sets it.
  - For compare values 1 to 0xFE the pin is high for 2×compare ticks per period.
- R11: A control write with bit 7 set and a non-PWM mode applies the output action to the pin on that edge. It sets no flag and leaves the counter unchanged. In PWM modes the strobe has no effect.
- R12: After reset every register is 0 and the pin is low. `at_bottom` is high when the counter is 0x00 and `at_max` is high when it is 0xFF. With output action 0 the pin reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of register `addr` |
| ext_tick | input | 1 | Synchronized external count pulse |
| ack_ovf | input | 1 | Overflow interrupt acknowledge |
| ack_cmp | input | 1 | Compare interrupt acknowledge |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |
| wave_out | output | 1 | Waveform output pin |
| at_bottom | output | 1 | Counter equals 0x00 |
| at_max | output | 1 | Counter equals 0xFF |

## Verification
Single external ticks step the counter one state at a time. This separates the edge that sees a match from the edge that raises the flag, and a buffered compare value from an immediate one.

In fast PWM, compare values are swept from 0 to 0xFF in steps of 5, and the high time measured over one period must equal compare+1. This exposes any off-by-one at either end of the range and checks that the set at 0xFF wins over the match.

In phase-correct PWM, compare values from 1 to 0xFE are swept in the same way against 2×compare. This tells a wrong turn-around or a wrong direction sense apart from a correct waveform.

Fixed windows of 64 and 128 clocks check the prescaled tick rates without depending on the prescaler's phase.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;

  typedef enum logic [1:0] {
    CM_NORMAL = 2'd0,
    CM_CLEAR  = 2'd1,
    CM_FAST   = 2'd2,
    CM_PHASE  = 2'd3
  } cnt_mode_e;

  typedef struct packed {
    logic [1:0] omode;
    cnt_mode_e  mode;
    logic [2:0] src;
  } ctrl_t;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CNT  = 3'd1;
  localparam logic [2:0] A_CMP  = 3'd2;
  localparam logic [2:0] A_FLAG = 3'd3;
  localparam logic [2:0] A_IEN  = 3'd4;

  function automatic logic is_pwm(cnt_mode_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/tmr_oc_prescale.sv
module tmr_oc_prescale #(
  parameter int SLOW_LOG2   = 3,
  parameter int SLOWER_LOG2 = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] src,
  input  logic       ext_tick,
  output logic       tick
);
  localparam int PW   = SLOWER_LOG2;
  localparam int NDIV = 2;
  localparam int DLOG [NDIV] = '{SLOW_LOG2, SLOWER_LOG2};

  logic [PW-1:0]   pc;
  logic [NDIV-1:0] div_tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pc <= '0;
    else        pc <= pc + 1'b1;

  for (genvar g = 0; g < NDIV; g++) begin : g_tap
    assign div_tick[g] = &pc[DLOG[g]-1:0];
  end

  always_comb begin
    case (src)
      3'd1:    tick = 1'b1;
      3'd2:    tick = div_tick[0];
      3'd3:    tick = div_tick[1];
      3'd4:    tick = ext_tick;
      default: tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_oc_counter.sv
module tmr_oc_counter
  import tmr_oc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  cnt_mode_e    mode,
  input  logic         match,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         rising,
  output logic         at_bottom,
  output logic         at_max,
  output logic         ovf_evt
);
  localparam logic [W-1:0] TOP = '1;

  assign at_bottom = (cnt == '0);
  assign at_max    = (cnt == TOP);
  assign ovf_evt   = tick & ((mode == CM_PHASE) ? at_bottom : at_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rising <= 1'b1;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick) begin
      case (mode)
        CM_CLEAR: cnt <= match ? '0 : cnt + 1'b1;
        CM_PHASE: begin
          if (rising) begin
            if (at_max) begin
              cnt    <= TOP - 1'b1;
              rising <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            if (at_bottom) begin
              cnt    <= {{(W-1){1'b0}}, 1'b1};
              rising <= 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        default:  cnt <= cnt + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/tmr_oc_compare.sv
module tmr_oc_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wval,
  input  logic         pwm,
  input  logic         reload,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] shadow,
  output logic         match
);
  logic [W-1:0] active;

  assign match = (cnt == active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
      shadow <= '0;
    end else begin
      if (wr) shadow <= wval;
      if (pwm && reload)   active <= shadow;
      else if (wr && !pwm) active <= wval;
    end
  end
endmodule

// File: rtl/tmr_oc_wave.sv
module tmr_oc_wave
  import tmr_oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  cnt_mode_e  mode,
  input  logic [1:0] omode,
  input  logic       match,
  input  logic       at_max,
  input  logic       rising,
  input  logic       force_req,
  input  logic [1:0] force_omode,
  output logic       wave
);
  function automatic logic step(logic [1:0] om, logic cur);
    case (om)
      2'd1:    return ~cur;
      2'd2:    return 1'b0;
      2'd3:    return 1'b1;
      default: return cur;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave <= 1'b0;
    end else if (force_req) begin
      wave <= step(force_omode, wave);
    end else if (tick) begin
      case (mode)
        CM_FAST: begin
          if (omode[1]) begin
            if (at_max)     wave <= ~omode[0];
            else if (match) wave <= omode[0];
          end
        end
        CM_PHASE: begin
          if (omode[1] && match) wave <= (rising == omode[0]);
        end
        default: begin
          if (match) wave <= step(omode, wave);
        end
      endcase
    end
  end
endmodule

// File: rtl/tmr_oc.sv
module tmr_oc
  import tmr_oc_pkg::*;
#(
  parameter int W           = 8,
  parameter int SLOW_LOG2   = 3,
  parameter int SLOWER_LOG2 = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         ext_tick,
  input  logic         ack_ovf,
  input  logic         ack_cmp,
  output logic         irq_ovf,
  output logic         irq_cmp,
  output logic         wave_out,
  output logic         at_bottom,
  output logic         at_max
);
  ctrl_t        ctrl_q, wctrl;
  logic [1:0]   ien_q;
  logic         ovf_f, cmp_f;
  logic         wr_ctrl, wr_cnt, wr_cmp, wr_flag, wr_ien;
  logic         tick, match, rising, ovf_evt, force_req, wave_q;
  logic [W-1:0] cnt_q, shadow;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_cnt  = wr_en && (addr == A_CNT);
  assign wr_cmp  = wr_en && (addr == A_CMP);
  assign wr_flag = wr_en && (addr == A_FLAG);
  assign wr_ien  = wr_en && (addr == A_IEN);

  assign wctrl     = ctrl_t'(wdata[6:0]);
  assign force_req = wr_ctrl && wdata[7] && !is_pwm(wctrl.mode);

  tmr_oc_prescale #(.SLOW_LOG2(SLOW_LOG2), .SLOWER_LOG2(SLOWER_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .src(ctrl_q.src), .ext_tick(ext_tick), .tick(tick)
  );

  tmr_oc_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(ctrl_q.mode), .match(match),
    .load(wr_cnt), .load_val(wdata), .cnt(cnt_q), .rising(rising),
    .at_bottom(at_bottom), .at_max(at_max), .ovf_evt(ovf_evt)
  );

  tmr_oc_compare #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .wr(wr_cmp), .wval(wdata),
    .pwm(is_pwm(ctrl_q.mode)), .reload(tick && at_max),
    .cnt(cnt_q), .shadow(shadow), .match(match)
  );

  tmr_oc_wave u_wave (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(ctrl_q.mode), .omode(ctrl_q.omode),
    .match(match), .at_max(at_max), .rising(rising),
    .force_req(force_req), .force_omode(wctrl.omode), .wave(wave_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      ovf_f  <= 1'b0;
      cmp_f  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wctrl;
      if (wr_ien)  ien_q  <= wdata[1:0];
      ovf_f <= ovf_evt | (ovf_f & ~(ack_ovf | (wr_flag & wdata[0])));
      cmp_f <= (tick & match) | (cmp_f & ~(ack_cmp | (wr_flag & wdata[1])));
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = W'({1'b0, ctrl_q});
      A_CNT:   rdata = cnt_q;
      A_CMP:   rdata = shadow;
      A_FLAG:  rdata = W'({cmp_f, ovf_f});
      A_IEN:   rdata = W'(ien_q);
      default: rdata = '0;
    endcase
  end

  assign irq_ovf  = ovf_f & ien_q[0];
  assign irq_cmp  = cmp_f & ien_q[1];
  assign wave_out = (ctrl_q.omode != 2'd0) & wave_q;
endmodule

// File: rtl/tmr_oc_chk.sv
module tmr_oc_chk
  import tmr_oc_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] cnt,
  input logic [2:0]   src,
  input cnt_mode_e    mode,
  input logic         tick,
  input logic         match,
  input logic         cmp_flag,
  input logic         ovf_flag
);
  logic wr_cnt;
  assign wr_cnt = wr_en && (addr == A_CNT);

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 3'd0 && !wr_cnt) |=> (cnt == $past(cnt))); // R1
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt == $past(wdata))); // R2
  AST_FLAG_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match) |=> cmp_flag); // R4
  AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> $past(tick && match)); // R4
  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_CLEAR && tick && match && !wr_cnt) |=> (cnt == '0)); // R6
  AST_NORMAL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CM_NORMAL && tick && cnt == '1 && !wr_cnt) |=> (cnt == '0 && ovf_flag)); // R7
endmodule

bind tmr_oc tmr_oc_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .cnt(cnt_q), .src(ctrl_q.src), .mode(ctrl_q.mode), .tick(tick),
  .match(match), .cmp_flag(cmp_f), .ovf_flag(ovf_f)
);

// File: tb/test_tmr_oc.sv
module test_tmr_oc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ext_tick = 1'b0, ack_ovf = 1'b0, ack_cmp = 1'b0;
  logic       irq_ovf, irq_cmp, wave_out, at_bottom, at_max;
  int         total = 0, bad = 0;
  logic       done = 1'b0;

  always #4 clk = ~clk;

  tmr_oc i_tmr_oc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ext_tick(ext_tick), .ack_ovf(ack_ovf), .ack_cmp(ack_cmp), .irq_ovf(irq_ovf),
    .irq_cmp(irq_cmp), .wave_out(wave_out), .at_bottom(at_bottom), .at_max(at_max)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_tick = 1'b1;
      @(negedge clk); ext_tick = 1'b0;
    end
  endtask

  task automatic wait_cnt(input logic [7:0] v);
    addr = 3'd1;
    do begin @(negedge clk); #1; end while (rdata != v);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic       w0;
    int         highs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    rd(3'd1, d); chk("R12 count", d, 0);
    rd(3'd3, d); chk("R12 flags", d, 0);
    rd(3'd0, d); chk("R12 ctrl", d, 0);
    chk("R12 wave", wave_out, 0);
    chk("R12 bottom", at_bottom, 1);

    // R1 stopped counter, still writable
    wr(3'd1, 8'h55);
    repeat (20) @(negedge clk);
    pulse(4);
    rd(3'd1, d); chk("R1 hold", d, 8'h55);
    // R3 sources 5..7 stop
    wr(3'd0, 8'd5); pulse(3); repeat (10) @(negedge clk);
    rd(3'd1, d); chk("R3 src5 stop", d, 8'h55);
    wr(3'd0, 8'd0);

    // R12 extreme indications
    wr(3'd1, 8'h00); chk("R12 at_bottom", at_bottom, 1); chk("R12 not max", at_max, 0);
    wr(3'd1, 8'hFF); chk("R12 at_max", at_max, 1); chk("R12 not bottom", at_bottom, 0);

    // R2 write wins over count (source 1 ticks every clock)
    wr(3'd0, 8'd1);
    wr(3'd1, 8'h40);
    rd(3'd1, d); chk("R2 write wins", d, 8'h40);
    @(negedge clk); rd(3'd1, d); chk("R2 count resumes", d, 8'h41);
    wr(3'd0, 8'd0);

    // R3 prescaled rates
    wr(3'd1, 8'h00); wr(3'd0, 8'd2);
    repeat (64) @(posedge clk);
    @(negedge clk); rd(3'd1, d); chk("R3 div8", d, 8);
    wr(3'd0, 8'd0); wr(3'd1, 8'h00); wr(3'd0, 8'd3);
    repeat (128) @(posedge clk);
    @(negedge clk); rd(3'd1, d); chk("R3 div64", d, 2);
    wr(3'd0, 8'd0);

    // R6 / R4 clear-on-compare with toggle, external ticks
    wr(3'd1, 8'h00); wr(3'd2, 8'd5); wr(3'd3, 8'h03);
    wr(3'd0, 8'd44);
    w0 = wave_out;
    pulse(5);
    rd(3'd1, d); chk("R6 count at match", d, 5);
    rd(3'd3, d); chk("R4 no flag during match", d[1], 0);
    pulse(1);
    rd(3'd1, d); chk("R6 clear on match", d, 0);
    rd(3'd3, d); chk("R4 flag after tick", d[1], 1);
    chk("R6 toggle", wave_out, !w0);
    wr(3'd0, 8'd108); pulse(6); chk("R6 set action", wave_out, 1);
    wr(3'd0, 8'd76);  pulse(6); chk("R6 clear action", wave_out, 0);

    // R5 flag clearing and interrupts
    wr(3'd3, 8'h02); rd(3'd3, d); chk("R5 write-one clear", d[1], 0);
    wr(3'd4, 8'h02); pulse(6);
    chk("R5 irq_cmp", irq_cmp, 1);
    @(negedge clk); ack_cmp = 1'b1; @(negedge clk); ack_cmp = 1'b0;
    rd(3'd3, d); chk("R5 ack clear", d[1], 0); chk("R5 irq drop", irq_cmp, 0);

    // R7 normal wrap and overflow
    wr(3'd0, 8'd0); wr(3'd1, 8'hF0); wr(3'd3, 8'h03); wr(3'd4, 8'h01);
    wr(3'd0, 8'd4);
    for (int i = 1; i <= 15; i++) begin
      pulse(1); rd(3'd1, d); chk("R7 count step", d, 8'hF0 + i);
    end
    rd(3'd3, d); chk("R7 no ovf at FF", d[0], 0);
    pulse(1);
    rd(3'd1, d); chk("R7 wrap", d, 0);
    rd(3'd3, d); chk("R7 ovf flag", d[0], 1);
    chk("R5 irq_ovf", irq_ovf, 1);
    wr(3'd3, 8'h01); rd(3'd3, d); chk("R5 ovf clear", d[0], 0);

    // R8 immediate compare in normal mode
    wr(3'd0, 8'd0); wr(3'd1, 8'd3); wr(3'd2, 8'd3); wr(3'd3, 8'h03);
    wr(3'd0, 8'd4); pulse(1);
    rd(3'd3, d); chk("R8 immediate compare", d[1], 1);

    // R8 / R9 buffered compare in fast PWM
    wr(3'd0, 8'd80); wr(3'd2, 8'h80); wr(3'd1, 8'hFE);
    wr(3'd0, 8'd84); pulse(2);
    rd(3'd1, d); chk("R9 wrap to 0", d, 0);
    chk("R9 set at max", wave_out, 1);
    wr(3'd2, 8'h20); pulse(8'h21);
    chk("R8 buffered write not active", wave_out, 1);
    rd(3'd2, d); chk("R8 buffer readback", d, 8'h20);
    pulse(8'h60);
    chk("R9 clear at old match", wave_out, 0);

    // R11 force strobe
    wr(3'd0, 8'd0); wr(3'd3, 8'h03); wr(3'd1, 8'h33);
    wr(3'd0, 8'd96); wr(3'd0, 8'd224);
    chk("R11 force set", wave_out, 1);
    rd(3'd3, d); chk("R11 no flag", d, 0);
    rd(3'd1, d); chk("R11 count kept", d, 8'h33);
    wr(3'd0, 8'd0);  chk("R12 disconnected", wave_out, 0);
    wr(3'd0, 8'd32); w0 = wave_out; wr(3'd0, 8'd160);
    chk("R11 force toggle", wave_out, !w0);
    wr(3'd0, 8'd80); w0 = wave_out; wr(3'd0, 8'd208);
    chk("R11 ignored in PWM", wave_out, w0);

    // R9 fast PWM duty sweep
    wr(3'd0, 8'd81);
    for (int o = 0; o < 256; o += 5) begin
      wr(3'd2, 8'(o));
      wait_cnt(8'hFF);
      highs = 0;
      for (int i = 0; i < 256; i++) begin
        @(negedge clk); #1;
        highs += int'(wave_out);
      end
      chk("R9 fast duty", highs, o + 1);
    end
    wr(3'd0, 8'd113); wr(3'd2, 8'h40);
    wait_cnt(8'hFF);
    highs = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); #1;
      highs += int'(wave_out);
    end
    chk("R9 inverted duty", highs, 255 - 8'h40);

    // R10 phase-correct sweep
    wr(3'd0, 8'd89);
    for (int o = 1; o < 255; o += 9) begin
      wr(3'd2, 8'(o));
      wait_cnt(8'hFF);
      wait_cnt(8'h00);
      highs = int'(wave_out);
      for (int i = 1; i < 510; i++) begin
        @(negedge clk); #1;
        highs += int'(wave_out);
      end
      chk("R10 phase duty", highs, 2 * o);
    end
    // R7 overflow at bottom in phase-correct mode
    wait_cnt(8'hFF);
    wr(3'd3, 8'h01);
    rd(3'd3, d); chk("R7 phase ovf cleared", d[0], 0);
    wait_cnt(8'h00);
    rd(3'd3, d); chk("R7 phase no ovf yet", d[0], 0);
    @(negedge clk); rd(3'd3, d); chk("R7 phase ovf at bottom", d[0], 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule